// File: doc/BRIEF.md
# Call-Return Stack with Trap Control

This block holds the hardware return stack of a processor's instruction unit. It also raises the trap requests that belong with that stack. A procedure call pushes one entry, which holds the return PC and the return local-frame base (L). A return pops the newest entry and delivers it on the outputs one cycle later. A trap-return does the same and also sets the trap enable again.

Next to the stack, the block checks three things. It watches the data-stack pointer on every push of the data stack and compares it with a limit that software sets. It watches its own stack depth against an early-warning threshold. It listens to a reschedule line. Every cycle it chooses at most one trap and sends it out as a one-cycle request with a 2-bit cause code. Maskable traps clear the global enable when they are taken. Underflow cannot be masked, and it also clears the enable when it is taken. A reschedule that arrives while traps are disabled is kept until traps are enabled again. Fetching the trap vector and migrating frames to memory are handled outside this block.

Top module: `callret_trap_unit`

## Requirements
- R1: After reset the stack is empty, `trap_en` is 1, and `trap_req` and `ret_valid` are 0.
- R2: A call pushes the pair (`call_pc`, `call_l`). A return (`ret_i` or `rett_i`) on a non-empty stack pops the newest pair in LIFO order. `ret_valid` goes to 1 with that pair on `ret_pc`/`ret_l` in the cycle after the return.
- R3: A return on an empty stack raises an underflow trap (cause 0) whether or not traps are enabled. It delivers no entry, and the stack stays empty.
- R4: A call made while the depth is already at least DEPTH-RESERVE (12 by default) raises a return-stack overflow trap (cause 1) when traps are enabled. The call is still pushed, and the reserve entries above the threshold can still be used by later calls.
- R5: A data-stack push (`s_inc`) raises a data-stack overflow trap (cause 2) when traps are enabled and (`s_ptr`+1) modulo 2^SW equals `s_limit`. In all other cases it raises no trap.
- R6: While `trap_en` is 0, no return-stack overflow, data-stack overflow or reschedule trap is raised.
- R7: Taking any trap clears `trap_en` at the same edge that raises `trap_req`. A trap-return that causes no trap sets `trap_en` to 1.
- R8: A reschedule request seen while traps are disabled is held pending. It is taken as a cause 3 trap once traps are enabled again.
- R9: When several trap conditions occur in the same cycle, the priority is underflow, then return-stack overflow, then data-stack overflow, then reschedule. A reschedule that loses stays pending.
- R10: `trap_req` is a registered pulse. It is 1 for exactly the one cycle after each taken trap, with `trap_cause` valid alongside it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Procedure call, pushes one entry |
| call_pc | input | PC_W | Return PC to push |
| call_l | input | L_W | Return L to push |
| ret_i | input | 1 | Plain return, pops one entry |
| rett_i | input | 1 | Trap-return, pops one entry and sets the enable |
| s_inc | input | 1 | Data-stack pointer is about to be incremented |
| s_ptr | input | SW | Current data-stack pointer |
| s_limit | input | SW | Data-stack limit set by software |
| resched_i | input | 1 | Reschedule request line |
| ret_pc | output | PC_W | Popped return PC |
| ret_l | output | L_W | Popped return L |
| ret_valid | output | 1 | Popped pair is valid this cycle |
| trap_req | output | 1 | One-cycle trap request |
| trap_cause | output | 2 | 0 underflow, 1 return-stack overflow, 2 data-stack overflow, 3 reschedule |
| trap_en | output | 1 | Maskable-trap enable |

## Verification
The assertions assume that `call_i`, `ret_i` and `rett_i` are mutually exclusive in any cycle. They also assume that no call arrives while all DEPTH entries are in use. The stimulus keeps to both assumptions. Every vector and directed step drives at most one of the three strobes. The overflow test stops pushing once the stack holds exactly DEPTH entries. Reschedule is driven as single-cycle pulses, so the held-pending path is exercised without the line staying high.

// File: rtl/crt_pkg.sv
package crt_pkg;

  // Trap cause codes; the numeric value is the field seen on trap_cause
  typedef enum logic [1:0] {
    CAUSE_UNDERFLOW = 2'd0,
    CAUSE_RS_OVF    = 2'd1,
    CAUSE_DS_OVF    = 2'd2,
    CAUSE_RESCHED   = 2'd3
  } cause_e;

  // True when incrementing s by one (modulo 2^sw) lands on lim
  function automatic logic next_hits_limit(input logic [31:0] s,
                                           input logic [31:0] lim,
                                           input int unsigned sw);
    logic [31:0] mask;
    mask = (32'd1 << sw) - 32'd1;
    return ((s + 32'd1) & mask) == (lim & mask);
  endfunction

  // True when the stack depth has reached the early-warning threshold
  function automatic logic in_reserve(input logic [31:0] depth,
                                      input logic [31:0] thresh);
    return depth >= thresh;
  endfunction

endpackage

// File: rtl/crt_lifo.sv
module crt_lifo #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  parameter int L_W   = 7,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic [PC_W-1:0] pc_in,
  input  logic [L_W-1:0]  l_in,
  output logic [PC_W-1:0] pop_pc,
  output logic [L_W-1:0]  pop_l,
  output logic            pop_valid,
  output logic [CW-1:0]   depth,
  output logic            empty_pop
);

  logic [PC_W-1:0] pc_mem [DEPTH];
  logic [L_W-1:0]  l_mem  [DEPTH];
  logic [CW-1:0]   cnt_q;
  logic            do_push;
  logic            do_pop;
  logic [IW-1:0]   wr_idx;
  logic [IW-1:0]   rd_idx;

  assign do_push   = push && (cnt_q < CW'(DEPTH));
  assign do_pop    = pop && !push && (cnt_q != '0);
  assign empty_pop = pop && !push && (cnt_q == '0);
  assign wr_idx    = IW'(cnt_q);
  assign rd_idx    = IW'(cnt_q - CW'(1));
  assign depth     = cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (do_push && wr_idx == IW'(g)) begin
        pc_mem[g] <= pc_in;
        l_mem[g]  <= l_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      pop_valid <= 1'b0;
      pop_pc    <= '0;
      pop_l     <= '0;
    end else begin
      pop_valid <= do_pop;
      if (do_push) begin
        cnt_q <= cnt_q + CW'(1);
      end else if (do_pop) begin
        cnt_q  <= cnt_q - CW'(1);
        pop_pc <= pc_mem[rd_idx];
        pop_l  <= l_mem[rd_idx];
      end
    end
  end

endmodule

// File: rtl/crt_arbiter.sv
module crt_arbiter
  import crt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unf_ev,
  input  logic       rso_ev,
  input  logic       dso_ev,
  input  logic       resched_line,
  input  logic       rett_ev,
  output logic       trap_req,
  output logic [1:0] trap_cause,
  output logic       trap_en,
  output logic       taken
);

  logic   pend_q;
  logic   want_rso;
  logic   want_dso;
  logic   want_rs;
  logic   take_rs;
  cause_e sel;

  assign want_rso = trap_en && rso_ev;
  assign want_dso = trap_en && dso_ev;
  assign want_rs  = trap_en && (pend_q || resched_line);
  assign take_rs  = want_rs && !unf_ev && !want_rso && !want_dso;
  assign taken    = unf_ev || want_rso || want_dso || want_rs;

  always_comb begin
    if (unf_ev)        sel = CAUSE_UNDERFLOW;
    else if (want_rso) sel = CAUSE_RS_OVF;
    else if (want_dso) sel = CAUSE_DS_OVF;
    else               sel = CAUSE_RESCHED;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_req   <= 1'b0;
      trap_cause <= 2'd0;
      trap_en    <= 1'b1;
      pend_q     <= 1'b0;
    end else begin
      trap_req <= taken;
      if (taken) trap_cause <= sel;
      if (taken)        trap_en <= 1'b0;
      else if (rett_ev) trap_en <= 1'b1;
      pend_q <= (pend_q || resched_line) && !take_rs;
    end
  end

endmodule

// File: rtl/callret_trap_unit.sv
module callret_trap_unit
  import crt_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int RESERVE = 4,
  parameter int PC_W    = 32,
  parameter int L_W     = 7,
  parameter int SW      = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_i,
  input  logic [PC_W-1:0] call_pc,
  input  logic [L_W-1:0]  call_l,
  input  logic            ret_i,
  input  logic            rett_i,
  input  logic            s_inc,
  input  logic [SW-1:0]   s_ptr,
  input  logic [SW-1:0]   s_limit,
  input  logic            resched_i,
  output logic [PC_W-1:0] ret_pc,
  output logic [L_W-1:0]  ret_l,
  output logic            ret_valid,
  output logic            trap_req,
  output logic [1:0]      trap_cause,
  output logic            trap_en
);

  localparam int CW     = $clog2(DEPTH + 1);
  localparam int THRESH = DEPTH - RESERVE;

  // Named internal events, visible to the bound checker
  logic          ret_any;
  logic [CW-1:0] depth_w;
  logic          unf_ev;
  logic          rso_ev;
  logic          dso_ev;
  logic          trap_taken;

  assign ret_any = ret_i || rett_i;
  assign rso_ev  = call_i && in_reserve(32'(depth_w), 32'(THRESH));
  assign dso_ev  = s_inc && next_hits_limit(32'(s_ptr), 32'(s_limit), SW);

  crt_lifo #(
    .DEPTH (DEPTH),
    .PC_W  (PC_W),
    .L_W   (L_W)
  ) u_lifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (call_i),
    .pop       (ret_any),
    .pc_in     (call_pc),
    .l_in      (call_l),
    .pop_pc    (ret_pc),
    .pop_l     (ret_l),
    .pop_valid (ret_valid),
    .depth     (depth_w),
    .empty_pop (unf_ev)
  );

  crt_arbiter u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .unf_ev       (unf_ev),
    .rso_ev       (rso_ev),
    .dso_ev       (dso_ev),
    .resched_line (resched_i),
    .rett_ev      (rett_i),
    .trap_req     (trap_req),
    .trap_cause   (trap_cause),
    .trap_en      (trap_en),
    .taken        (trap_taken)
  );

endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          call_i,
  input logic          ret_any,
  input logic          rett_i,
  input logic          resched_i,
  input logic          trap_taken,
  input logic [CW-1:0] depth,
  input logic          trap_req,
  input logic [1:0]    trap_cause,
  input logic          trap_en,
  input logic          ret_valid
);

  // R7
  trap_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !trap_en);

  // R3
  underflow_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_any && !call_i && depth == '0) |=> (trap_req && trap_cause == 2'd0 && depth == '0 && !ret_valid));

  // R2
  push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && !ret_any && depth < CW'(DEPTH)) |=> (depth == $past(depth) + CW'(1)));

  // R2
  pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_any && !call_i && depth != '0) |=> ret_valid);

  // R6
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && trap_cause != 2'd0) |-> $past(trap_en));

  // R8
  resched_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resched_i && !trap_en) |=> !(trap_req && trap_cause == 2'd3));

  // R7
  rett_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rett_i && !trap_taken) |=> trap_en);

endmodule

bind callret_trap_unit crt_checker #(
  .DEPTH (DEPTH),
  .CW    (CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .call_i     (call_i),
  .ret_any    (ret_any),
  .rett_i     (rett_i),
  .resched_i  (resched_i),
  .trap_taken (trap_taken),
  .depth      (depth_w),
  .trap_req   (trap_req),
  .trap_cause (trap_cause),
  .trap_en    (trap_en),
  .ret_valid  (ret_valid)
);

// File: tb/sim_callret_trap_unit.sv
module sim_callret_trap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0;
  logic [31:0] call_pc = '0;
  logic [6:0]  call_l = '0;
  logic        ret_i = 1'b0;
  logic        rett_i = 1'b0;
  logic        s_inc = 1'b0;
  logic [6:0]  s_ptr = '0;
  logic [6:0]  s_limit = '0;
  logic        resched_i = 1'b0;
  logic [31:0] ret_pc;
  logic [6:0]  ret_l;
  logic        ret_valid;
  logic        trap_req;
  logic [1:0]  trap_cause;
  logic        trap_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  callret_trap_unit u0 (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .call_pc(call_pc), .call_l(call_l),
    .ret_i(ret_i), .rett_i(rett_i), .s_inc(s_inc), .s_ptr(s_ptr), .s_limit(s_limit),
    .resched_i(resched_i), .ret_pc(ret_pc), .ret_l(ret_l), .ret_valid(ret_valid),
    .trap_req(trap_req), .trap_cause(trap_cause), .trap_en(trap_en)
  );

  typedef struct packed {
    logic        call;
    logic [31:0] pc;
    logic [6:0]  l;
    logic        ret;
    logic        rett;
    logic        sinc;
    logic [6:0]  sp;
    logic [6:0]  lim;
    logic        rs;
    logic        e_trap;
    logic [1:0]  e_cause;
    logic        e_en;
    logic        e_rv;
    logic [31:0] e_pc;
    logic [6:0]  e_l;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 32'd100, 7'd5, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'd0,   7'd0},
    '{1'b1, 32'd200, 7'd9, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b1, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'd200, 7'd9},
    '{1'b0, 32'd0,   7'd0, 1'b1, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'd100, 7'd5},
    '{1'b0, 32'd0,   7'd0, 1'b1, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b1, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b0, 1'b1, 7'd20,  7'd21, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b1, 32'd300, 7'd3, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b1, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'd300, 7'd3},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b1, 32'd400, 7'd1, 1'b0, 1'b0, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b1, 1'b0, 7'd0,   7'd0,  1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'd400, 7'd1},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b0, 1'b1, 7'd20,  7'd30, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b0, 1'b1, 7'd127, 7'd0,  1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 32'd0,   7'd0},
    '{1'b0, 32'd0,   7'd0, 1'b0, 1'b1, 1'b0, 7'd0,   7'd0,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 32'd0,   7'd0}
  };
  // Requirement exercised by each row
  localparam string TAG [NV] = '{
    "R2", "R2", "R2", "R2", "R3", "R3", "R8", "R6", "R8",
    "R6", "R7", "R8", "R7", "R7", "R5", "R5", "R7"
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic [31:0] pc, input logic [6:0] l,
                      input logic r, input logic rt, input logic si,
                      input logic [6:0] sp, input logic [6:0] lim, input logic rs);
    @(negedge clk);
    call_i = c; call_pc = pc; call_l = l; ret_i = r; rett_i = rt;
    s_inc = si; s_ptr = sp; s_limit = lim; resched_i = rs;
    @(posedge clk);
    #1;
    call_i = 1'b0; ret_i = 1'b0; rett_i = 1'b0; s_inc = 1'b0; resched_i = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 32'd0, 7'd0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic trap_is(input string req, input logic t, input logic [1:0] c, input logic en);
    chk(req, "trap_req", 32'(trap_req), 32'(t));
    if (t) chk(req, "trap_cause", 32'(trap_cause), 32'(c));
    chk(req, "trap_en", 32'(trap_en), 32'(en));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    do_reset();
    #1;
    trap_is("R1", 1'b0, 2'd0, 1'b1);
    chk("R1", "ret_valid", 32'(ret_valid), 32'd0);
    step(1'b0, 32'd0, 7'd0, 1'b1, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
    trap_is("R1", 1'b1, 2'd0, 1'b0);  // empty after reset: underflow

    // Vector table walk from a fresh reset
    do_reset();
    for (int i = 0; i < NV; i++) begin
      step(TBL[i].call, TBL[i].pc, TBL[i].l, TBL[i].ret, TBL[i].rett,
           TBL[i].sinc, TBL[i].sp, TBL[i].lim, TBL[i].rs);
      trap_is(TAG[i], TBL[i].e_trap, TBL[i].e_cause, TBL[i].e_en);
      chk(TAG[i], "ret_valid", 32'(ret_valid), 32'(TBL[i].e_rv));
      if (TBL[i].e_rv) begin
        chk(TAG[i], "ret_pc", ret_pc, TBL[i].e_pc);
        chk(TAG[i], "ret_l", 32'(ret_l), 32'(TBL[i].e_l));
      end
    end

    // R4: early return-stack overflow with usable reserve
    do_reset();
    for (int i = 0; i < 12; i++) begin
      step(1'b1, 32'(1000 + i), 7'(i), 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
      trap_is("R4", 1'b0, 2'd0, 1'b1);
    end
    step(1'b1, 32'd1012, 7'd12, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
    trap_is("R4", 1'b1, 2'd1, 1'b0);
    for (int i = 13; i < 16; i++) begin
      step(1'b1, 32'(1000 + i), 7'(i), 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
      trap_is("R4", 1'b0, 2'd0, 1'b0);
    end
    step(1'b0, 32'd0, 7'd0, 1'b1, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
    chk("R4", "ret_pc top of full stack", ret_pc, 32'd1015);
    chk("R4", "ret_l top of full stack", 32'(ret_l), 32'd15);
    step(1'b0, 32'd0, 7'd0, 1'b0, 1'b1, 1'b0, 7'd0, 7'd0, 1'b0);
    chk("R4", "ret_pc after rett", ret_pc, 32'd1014);
    trap_is("R7", 1'b0, 2'd0, 1'b1);
    step(1'b1, 32'd2000, 7'd0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
    trap_is("R4", 1'b1, 2'd1, 1'b0);

    // R9: underflow beats data-stack overflow and reschedule
    do_reset();
    step(1'b0, 32'd0, 7'd0, 1'b1, 1'b0, 1'b1, 7'd20, 7'd21, 1'b1);
    trap_is("R9", 1'b1, 2'd0, 1'b0);
    idle();
    trap_is("R10", 1'b0, 2'd0, 1'b0);
    step(1'b1, 32'd7, 7'd7, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
    step(1'b0, 32'd0, 7'd0, 1'b0, 1'b1, 1'b0, 7'd0, 7'd0, 1'b0);
    trap_is("R9", 1'b0, 2'd0, 1'b1);
    idle();
    trap_is("R9", 1'b1, 2'd3, 1'b0);  // losing reschedule stayed pending

    // R9: return-stack overflow beats data-stack overflow and reschedule
    do_reset();
    for (int i = 0; i < 12; i++) step(1'b1, 32'(i), 7'd0, 1'b0, 1'b0, 1'b0, 7'd0, 7'd0, 1'b0);
    step(1'b1, 32'd99, 7'd0, 1'b0, 1'b0, 1'b1, 7'd5, 7'd6, 1'b1);
    trap_is("R9", 1'b1, 2'd1, 1'b0);

    // R9: data-stack overflow beats reschedule; R10 single pulse
    do_reset();
    step(1'b0, 32'd0, 7'd0, 1'b0, 1'b0, 1'b1, 7'd40, 7'd41, 1'b1);
    trap_is("R9", 1'b1, 2'd2, 1'b0);
    idle();
    trap_is("R10", 1'b0, 2'd0, 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule